// File: doc/BRIEF.md
# Per-Thread Recency-Rank Hit Counters

This block gives a cache allocator running estimates of how much each hardware thread would gain from owning more ways of a shared set-associative cache. Each access to the cache is reported with the requesting thread, a hit or miss flag, and, for a hit, the rank of the hit block within that thread's own recency order in the set. Rank 0 is the thread's most recently used block, rank 1 its next most recent, and so on. The block keeps one saturating counter per thread and rank. The counter at rank k estimates how many extra hits the thread would see if it owned k+1 ways instead of k.

To let recent behaviour dominate, all counters are decayed together after a fixed number of reported references. Decay subtracts a right-shifted copy of each counter from itself, which amounts to multiplying by a weight just below one. The shift amount is an input. Hit reports pass through a small event queue, so that counter updates stay off the lookup path. Hits that find the queue full are discarded and tallied in a saturating drop count. The allocator fetches any counter through a registered read port.

Top module: `thread_rank_hit_counters`

## Requirements
- R1: While reset is asserted and after it is released, every counter reads 0, `fifo_full` is 0 and `drop_cnt` is 0.
- R2: A hit reported by thread t at rank r (rank 0 being the thread's most recently used block) adds exactly 1 to counter (t, r) and changes no other counter.
- R3: A reported miss (`ev_valid`=1, `ev_hit`=0) changes no counter.
- R4: `rd_data` shows the counter selected by `rd_thread`/`rd_rank` at a rising clock edge from that edge on: it has one cycle of latency and keeps its old value until the edge.
- R5: Every `ev_valid` cycle is one reference, whether it is a hit or a miss and whether it is kept or dropped. At every DECAY_PERIOD-th reference, every counter c becomes c - (c >> `decay_shift`), all in the same cycle.
- R6: Decay takes precedence over a pending increment. A hit that is queued or held when decay occurs, including the hit that completes the period, is added after the decay.
- R7: A counter at 2^CNT_W-1 stays there on further hits.
- R8: The event queue holds FIFO_DEPTH hits. `fifo_full` is 1 while it is full, and a hit reported while `fifo_full` is 1 is discarded without touching any counter.
- R9: `drop_cnt` rises by 1 for each discarded hit, saturates at 2^DROP_W-1, and never decreases except by reset.
- R10: The queue drains one hit every two cycles. Hits reported at most once every two cycles are never dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_valid | input | 1 | One cache reference is reported this cycle |
| ev_thread | input | TW | Requesting thread index |
| ev_hit | input | 1 | 1 = hit, 0 = miss |
| ev_rank | input | RKW | Recency rank of the hit block among the thread's blocks (0 = most recent) |
| decay_shift | input | SHIFT_W | Right-shift amount S used by decay |
| rd_thread | input | TW | Thread index of the counter to read |
| rd_rank | input | RKW | Rank index of the counter to read |
| rd_data | output | CNT_W | Selected counter, registered |
| fifo_full | output | 1 | Event queue full; hits now are dropped |
| drop_cnt | output | DROP_W | Saturating count of dropped hits |

## Verification
A table of spaced hits and misses, spread over every thread and several ranks, is replayed against a reference model. This separates correct per-(thread, rank) steering from cross-talk and shows that misses leave the counters alone. A directed run puts a hit on the reference that completes a decay period; its result differs depending on whether the increment lands before or after the decay. Back-to-back hit bursts exercise queue overflow: the kept and dropped hits must add up to the number sent, and the drop tally must saturate. A long run of hits to one counter exposes wrap-around against saturation.

// File: rtl/hpc_pkg.sv
package hpc_pkg;

  // Index width for a range of n values; at least one bit.
  function automatic int unsigned idx_w(input int unsigned n);
    return (n <= 1) ? 1 : $clog2(n);
  endfunction

endpackage

// File: rtl/hpc_event_fifo.sv
module hpc_event_fifo #(
  parameter int unsigned W     = 5,
  parameter int unsigned DEPTH = 4,
  localparam int unsigned PW   = hpc_pkg::idx_w(DEPTH),
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_i,
  input  logic [W-1:0]  data_i,
  input  logic          pop_i,
  output logic [W-1:0]  data_o,
  output logic          empty_o,
  output logic          full_o,
  output logic [CW-1:0] cnt_o
);

  logic [W-1:0]  mem_q [DEPTH];
  logic [PW-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          do_push, do_pop;

  assign full_o  = (cnt_q == CW'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign cnt_o   = cnt_q;
  assign data_o  = mem_q[rd_q];
  assign do_push = push_i & ~full_o;
  assign do_pop  = pop_i & ~empty_o;

  always_comb begin
    wr_d  = wr_q;
    rd_d  = rd_q;
    cnt_d = cnt_q;
    if (do_push) wr_d = (wr_q == PW'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
    if (do_pop)  rd_d = (rd_q == PW'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
    if (do_push && !do_pop)      cnt_d = cnt_q + 1'b1;
    else if (do_pop && !do_push) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem_q[wr_q] <= data_i;
  end

endmodule

// File: rtl/hpc_decay_timer.sv
module hpc_decay_timer #(
  parameter int unsigned PERIOD = 200000,
  localparam int unsigned RW    = hpc_pkg::idx_w(PERIOD)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_i,
  output logic tick_o
);

  logic [RW-1:0] cnt_q, cnt_d;
  logic          tick_q, tick_d;
  logic          last;

  assign last   = (cnt_q == RW'(PERIOD - 1));
  assign tick_o = tick_q;

  always_comb begin
    cnt_d  = cnt_q;
    tick_d = 1'b0;
    if (ref_i) begin
      cnt_d  = last ? '0 : cnt_q + 1'b1;
      tick_d = last;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      tick_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      tick_q <= tick_d;
    end
  end

endmodule

// File: rtl/hpc_rank_counter_array.sv
module hpc_rank_counter_array #(
  parameter int unsigned NT      = 4,
  parameter int unsigned NW      = 8,
  parameter int unsigned CNT_W   = 16,
  parameter int unsigned SHIFT_W = 4,
  parameter int unsigned TW      = 2,
  parameter int unsigned RKW     = 3,
  localparam int unsigned TOT    = NT * NW
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               decay_i,
  input  logic [SHIFT_W-1:0] shift_i,
  input  logic               evt_valid_i,
  input  logic [TW-1:0]      evt_thread_i,
  input  logic [RKW-1:0]     evt_rank_i,
  output logic               pop_o,
  output logic               inc_fire_o,
  input  logic [TW-1:0]      rd_thread_i,
  input  logic [RKW-1:0]     rd_rank_i,
  output logic [CNT_W-1:0]   rd_data_o
);

  localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q [TOT];
  logic [CNT_W-1:0] cnt_d [TOT];
  logic             hold_vld_q, hold_vld_d;
  logic [TW-1:0]    hold_thr_q;
  logic [RKW-1:0]   hold_rnk_q;
  logic [31:0]      hold_idx, rd_idx;
  logic             hold_ok, rd_ok;
  logic [CNT_W-1:0] rd_next;

  // Stage 1 takes an event from the queue, stage 2 applies it.
  assign pop_o      = evt_valid_i & ~hold_vld_q;
  assign inc_fire_o = hold_vld_q & ~decay_i;

  assign hold_idx = 32'(hold_thr_q) * NW + 32'(hold_rnk_q);
  assign hold_ok  = (32'(hold_thr_q) < NT) && (32'(hold_rnk_q) < NW);
  assign rd_idx   = 32'(rd_thread_i) * NW + 32'(rd_rank_i);
  assign rd_ok    = (32'(rd_thread_i) < NT) && (32'(rd_rank_i) < NW);

  always_comb begin
    hold_vld_d = hold_vld_q;
    if (pop_o)           hold_vld_d = 1'b1;
    else if (inc_fire_o) hold_vld_d = 1'b0;
  end

  always_comb begin
    for (int i = 0; i < TOT; i++) begin
      cnt_d[i] = cnt_q[i];
      if (decay_i)
        cnt_d[i] = cnt_q[i] - (cnt_q[i] >> shift_i);
      else if (inc_fire_o && hold_ok && hold_idx == 32'(i) && cnt_q[i] != CMAX)
        cnt_d[i] = cnt_q[i] + 1'b1;
    end
  end

  always_comb begin
    rd_next = '0;
    for (int i = 0; i < TOT; i++)
      if (rd_ok && rd_idx == 32'(i)) rd_next = cnt_q[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < TOT; i++) cnt_q[i] <= '0;
      hold_vld_q <= 1'b0;
      hold_thr_q <= '0;
      hold_rnk_q <= '0;
      rd_data_o  <= '0;
    end else begin
      for (int i = 0; i < TOT; i++) cnt_q[i] <= cnt_d[i];
      hold_vld_q <= hold_vld_d;
      if (pop_o) begin
        hold_thr_q <= evt_thread_i;
        hold_rnk_q <= evt_rank_i;
      end
      rd_data_o <= rd_next;
    end
  end

endmodule

// File: rtl/thread_rank_hit_counters.sv
module thread_rank_hit_counters #(
  parameter int unsigned NUM_THREADS  = 4,
  parameter int unsigned NUM_WAYS     = 8,
  parameter int unsigned CNT_W        = 16,
  parameter int unsigned DECAY_PERIOD = 200000,
  parameter int unsigned FIFO_DEPTH   = 4,
  parameter int unsigned DROP_W       = 8,
  parameter int unsigned SHIFT_W      = 4,
  localparam int unsigned TW          = hpc_pkg::idx_w(NUM_THREADS),
  localparam int unsigned RKW         = hpc_pkg::idx_w(NUM_WAYS),
  localparam int unsigned FCW         = $clog2(FIFO_DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ev_valid,
  input  logic [TW-1:0]      ev_thread,
  input  logic               ev_hit,
  input  logic [RKW-1:0]     ev_rank,
  input  logic [SHIFT_W-1:0] decay_shift,
  input  logic [TW-1:0]      rd_thread,
  input  logic [RKW-1:0]     rd_rank,
  output logic [CNT_W-1:0]   rd_data,
  output logic               fifo_full,
  output logic [DROP_W-1:0]  drop_cnt
);

  localparam int unsigned EW = TW + RKW;

  logic           hit_in, push, drop;
  logic           q_empty, pop, decay_tick, inc_fire;
  logic [EW-1:0]  q_out;
  logic [FCW-1:0] fifo_cnt;
  logic [DROP_W-1:0] drop_q, drop_d;

  assign hit_in = ev_valid & ev_hit;
  assign push   = hit_in & ~fifo_full;
  assign drop   = hit_in & fifo_full;

  hpc_event_fifo #(.W(EW), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n),
    .push_i(push), .data_i({ev_thread, ev_rank}),
    .pop_i(pop), .data_o(q_out),
    .empty_o(q_empty), .full_o(fifo_full), .cnt_o(fifo_cnt)
  );

  hpc_decay_timer #(.PERIOD(DECAY_PERIOD)) u_timer (
    .clk(clk), .rst_n(rst_n), .ref_i(ev_valid), .tick_o(decay_tick)
  );

  hpc_rank_counter_array #(
    .NT(NUM_THREADS), .NW(NUM_WAYS), .CNT_W(CNT_W),
    .SHIFT_W(SHIFT_W), .TW(TW), .RKW(RKW)
  ) u_array (
    .clk(clk), .rst_n(rst_n),
    .decay_i(decay_tick), .shift_i(decay_shift),
    .evt_valid_i(~q_empty),
    .evt_thread_i(q_out[EW-1:RKW]), .evt_rank_i(q_out[RKW-1:0]),
    .pop_o(pop), .inc_fire_o(inc_fire),
    .rd_thread_i(rd_thread), .rd_rank_i(rd_rank),
    .rd_data_o(rd_data)
  );

  always_comb begin
    drop_d = drop_q;
    if (drop && drop_q != {DROP_W{1'b1}}) drop_d = drop_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) drop_q <= '0;
    else        drop_q <= drop_d;
  end

  assign drop_cnt = drop_q;

endmodule

// File: rtl/hpc_counters_chk.sv
module hpc_counters_chk #(
  parameter int unsigned FIFO_DEPTH = 4,
  parameter int unsigned DROP_W     = 8,
  parameter int unsigned FCW        = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ev_valid,
  input logic              ev_hit,
  input logic              fifo_full,
  input logic [DROP_W-1:0] drop_cnt,
  input logic [FCW-1:0]    fifo_cnt,
  input logic              decay_tick,
  input logic              inc_fire
);

  // R8
  fifo_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_cnt <= FCW'(FIFO_DEPTH));

  // R8
  drop_on_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid && ev_hit && fifo_full && drop_cnt != {DROP_W{1'b1}})
      |=> drop_cnt == $past(drop_cnt) + 1'b1);

  // R9
  drop_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drop_cnt >= $past(drop_cnt));

  // R10
  no_drop_with_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!fifo_full) |=> drop_cnt == $past(drop_cnt));

  // R6
  decay_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    decay_tick |-> !inc_fire);

  // R5
  decay_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    decay_tick |=> !decay_tick);

endmodule

bind thread_rank_hit_counters hpc_counters_chk #(
  .FIFO_DEPTH(FIFO_DEPTH), .DROP_W(DROP_W), .FCW(FCW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_hit(ev_hit),
  .fifo_full(fifo_full), .drop_cnt(drop_cnt), .fifo_cnt(fifo_cnt),
  .decay_tick(decay_tick), .inc_fire(inc_fire)
);

// File: tb/test_thread_rank_hit_counters.sv
module test_thread_rank_hit_counters;

  localparam int NT = 4, NW = 4, CW = 6, PER = 10, DEPTH = 4, DW = 4, SW = 3;
  localparam int CMAX = (1 << CW) - 1;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          ev_valid, ev_hit;
  logic [1:0]    ev_thread, ev_rank, rd_thread, rd_rank;
  logic [SW-1:0] decay_shift;
  logic [CW-1:0] rd_data;
  logic          fifo_full;
  logic [DW-1:0] drop_cnt;

  thread_rank_hit_counters #(
    .NUM_THREADS(NT), .NUM_WAYS(NW), .CNT_W(CW), .DECAY_PERIOD(PER),
    .FIFO_DEPTH(DEPTH), .DROP_W(DW), .SHIFT_W(SW)
  ) i_thread_rank_hit_counters (
    .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_thread(ev_thread),
    .ev_hit(ev_hit), .ev_rank(ev_rank), .decay_shift(decay_shift),
    .rd_thread(rd_thread), .rd_rank(rd_rank), .rd_data(rd_data),
    .fifo_full(fifo_full), .drop_cnt(drop_cnt)
  );

  always #5 clk = ~clk;

  // Stimulus table: {thread[1:0], hit, rank[1:0]}
  localparam logic [4:0] VEC [24] = '{
    5'b00_1_00, 5'b01_1_01, 5'b10_1_10, 5'b11_1_11, 5'b00_0_00, 5'b00_1_00,
    5'b01_1_00, 5'b10_0_11, 5'b11_1_00, 5'b00_1_01, 5'b00_1_00, 5'b01_1_01,
    5'b10_1_10, 5'b10_1_10, 5'b11_0_01, 5'b00_1_00, 5'b01_1_11, 5'b11_1_11,
    5'b00_1_00, 5'b10_1_10, 5'b00_1_00, 5'b01_0_01, 5'b11_1_00, 5'b00_1_11
  };

  int exp_c [NT][NW];
  int refs, shamt, checks, fails;
  bit done;

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  task automatic model_clear();
    for (int t = 0; t < NT; t++) for (int r = 0; r < NW; r++) exp_c[t][r] = 0;
    refs = 0;
  endtask

  task automatic model_ref(input int t, input bit h, input int r);
    refs++;
    if (refs == PER) begin
      refs = 0;
      for (int a = 0; a < NT; a++)
        for (int b = 0; b < NW; b++) exp_c[a][b] = exp_c[a][b] - (exp_c[a][b] >> shamt);
    end
    if (h && exp_c[t][r] < CMAX) exp_c[t][r]++;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    model_clear();
  endtask

  task automatic send(input int t, input bit h, input int r);
    @(negedge clk);
    ev_valid = 1'b1; ev_thread = 2'(t); ev_hit = h; ev_rank = 2'(r);
    @(negedge clk);
    ev_valid = 1'b0;
    repeat (3) @(negedge clk);
    model_ref(t, h, r);
  endtask

  task automatic rd(input int t, input int r, output int v);
    @(negedge clk);
    rd_thread = 2'(t); rd_rank = 2'(r);
    @(negedge clk);
    v = int'(rd_data);
  endtask

  task automatic check_all(input string req);
    int v;
    for (int t = 0; t < NT; t++)
      for (int r = 0; r < NW; r++) begin
        rd(t, r, v);
        chk(v == exp_c[t][r], req, v, exp_c[t][r]);
      end
  endtask

  task automatic burst(input int t, input int r, input int n, output bit seen_full);
    seen_full = 1'b0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (fifo_full) seen_full = 1'b1;
      ev_valid = 1'b1; ev_hit = 1'b1; ev_thread = 2'(t); ev_rank = 2'(r);
    end
    @(negedge clk);
    ev_valid = 1'b0;
    repeat (20) @(negedge clk);
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      summary();
      $finish;
    end
  end

  initial begin
    int v;
    bit seen;
    rst_n = 1'b1; ev_valid = 1'b0; ev_hit = 1'b0; ev_thread = '0; ev_rank = '0;
    rd_thread = '0; rd_rank = '0; decay_shift = 3'd1; shamt = 1;
    checks = 0; fails = 0; done = 1'b0;

    // R1: reset state
    do_reset();
    check_all("R1 reset counters");
    chk(fifo_full == 1'b0, "R1 fifo_full", int'(fifo_full), 0);
    chk(drop_cnt == '0, "R1 drop_cnt", int'(drop_cnt), 0);

    // R2 R3 R5: table walk with decay at every 10th reference, shift 1
    foreach (VEC[i]) send(int'(VEC[i][4:3]), VEC[i][2], int'(VEC[i][1:0]));
    check_all("R2 R3 R5 table");
    // R10: spaced hits never dropped
    chk(drop_cnt == '0, "R10 no drop", int'(drop_cnt), 0);

    // R1: reset clears populated counters
    do_reset();
    check_all("R1 clear after use");

    // R3: misses alone leave counters at zero
    for (int k = 0; k < 6; k++) send(k % NT, 1'b0, k % NW);
    check_all("R3 misses only");

    // R6: hit completes the period; decay then increment: 5 -> 3 -> 4
    do_reset();
    for (int k = 0; k < 5; k++) send(0, 1'b1, 0);
    for (int k = 0; k < 4; k++) send(1, 1'b0, 2);
    send(0, 1'b1, 0);
    rd(0, 0, v);
    chk(v == 4, "R6 decay before pending hit", v, 4);
    chk(v == exp_c[0][0], "R6 model", v, exp_c[0][0]);

    // R5: shift 0 clears everything at the period
    do_reset();
    decay_shift = 3'd0; shamt = 0;
    for (int k = 0; k < 9; k++) send(2, 1'b1, 3);
    rd(2, 3, v);
    chk(v == 9, "R5 before period", v, 9);
    send(3, 1'b0, 0);
    rd(2, 3, v);
    chk(v == 0, "R5 shift 0 decay", v, 0);

    // R7: saturation, shift 7 makes decay a no-op for 6-bit counters
    do_reset();
    decay_shift = 3'd7; shamt = 7;
    for (int k = 0; k < 70; k++) send(3, 1'b1, 0);
    rd(3, 0, v);
    chk(v == CMAX, "R7 saturate", v, CMAX);

    // R4: one-cycle read latency
    rd(0, 0, v);
    chk(v == 0, "R4 first address", v, 0);
    @(negedge clk);
    rd_thread = 2'd3; rd_rank = 2'd0;
    #1;
    chk(rd_data == '0, "R4 old value before edge", int'(rd_data), 0);
    @(negedge clk);
    chk(rd_data == CW'(CMAX), "R4 new value after edge", int'(rd_data), CMAX);

    // R8 R9: back-to-back burst overflows the queue
    do_reset();
    burst(1, 2, 20, seen);
    chk(seen, "R8 fifo_full seen", int'(seen), 1);
    chk(fifo_full == 1'b0, "R8 fifo drained", int'(fifo_full), 0);
    rd(1, 2, v);
    chk(v + int'(drop_cnt) == 20, "R8 kept plus dropped", v + int'(drop_cnt), 20);
    chk(drop_cnt != '0, "R9 drops counted", int'(drop_cnt), 1);
    burst(2, 1, 60, seen);
    chk(drop_cnt == DW'((1 << DW) - 1), "R9 drop saturates", int'(drop_cnt), (1 << DW) - 1);
    repeat (10) @(negedge clk);
    chk(drop_cnt == DW'((1 << DW) - 1), "R9 drop sticky", int'(drop_cnt), (1 << DW) - 1);
    rd(0, 0, v);
    chk(v == 0, "R8 other counter untouched", v, 0);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule